// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of a four-bank SDRAM from reset until the memory can be used, and then keeps the memory refreshed. After reset it holds the bus in a no-operation state for a timed power-up interval, with the clock enable high and every byte mask high. It then closes every bank, issues a train of auto-refresh commands, and loads the mode register with a burst and latency setting fixed by parameters. Once the mode-load recovery time has passed, it raises a ready flag towards the host.

From then on an interval timer asks for one auto-refresh per average refresh period, which is 64 ms divided by 4096 rows. Each expired interval adds to a small pending count. The block raises a request whenever that count is non-zero. The host answers with a grant once all banks are idle, and the block issues the refresh on the next cycle. If the host holds the grant back for several periods, the pending count keeps the missed refreshes, up to a set limit, and pays them back in a burst.

All timing values are parameters in nanoseconds, microseconds or milliseconds. They are turned into clock cycles from a clock-frequency parameter, rounding up.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is high and in the first cycle after it, the pins show NOP (chip select 0, RAS 1, CAS 1, WE 1). Clock enable is 1, all byte masks are 1, bank and address are 0, and ready and the refresh request are 0.
- R2: Until ready rises, clock enable stays 1 and every byte mask stays 1. The grant input has no effect in this phase.
- R3: The first command is precharge-all: chip select 0, RAS 0, CAS 1, WE 0, with address bit 10 set to 1 and every other address and bank bit set to 0. It is driven exactly POWERUP_US × CLK_MHZ cycles after the last clock edge with reset high.
- R4: The first auto-refresh (chip select 0, RAS 0, CAS 0, WE 1) follows precharge-all by exactly ceil(TRP_NS × CLK_MHZ / 1000) cycles.
- R5: Exactly INIT_REFS auto-refreshes are issued during start-up. Consecutive ones are exactly ceil(TRC_NS × CLK_MHZ / 1000) cycles apart.
- R6: Each command lasts one cycle. NOP is driven in every cycle between commands.
- R7: The mode register set (chip select, RAS, CAS and WE all 0) follows the last start-up refresh by the tRC cycle count. Bank is 0 and address bits 11..7 are 0. Bits 6..4 carry CAS_LAT, bit 3 carries BURST_INTERLEAVE, and bits 2..0 carry BURST_LEN_CODE.
- R8: Ready rises exactly ceil(TRSC_NS × CLK_MHZ / 1000) cycles after the mode register set. It then stays high, and all byte masks go to 0 in the same cycle.
- R9: Once ready, one refresh interval expires every CLK_MHZ × REF_WINDOW_MS × 1000 / REF_ROWS cycles (integer division), the first one that many cycles after ready rises. The request goes high two cycles after an expiry and stays low while nothing is pending.
- R10: A grant seen while the request is high gives an auto-refresh in the next cycle. Outside start-up, an auto-refresh appears only after such a grant. A grant while the request is low has no effect. With the grant held high, run-mode refreshes are exactly one interval apart.
- R11: The pending count saturates at PEND_MAX. After a starvation longer than PEND_MAX intervals, exactly PEND_MAX refreshes are issued, each at least the tRC cycle count after the previous one, and the request then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Host grant: all banks idle, refresh may be issued |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W (2) | Bank address |
| sd_addr | output | ADDR_W (12) | Address bus |
| sd_dqm | output | DQM_W (8) | Byte masks |
| ready | output | 1 | Memory initialised and usable |
| ref_req | output | 1 | Refresh wanted, waiting for grant |

## Verification
The assertions check on every cycle that:
- the byte masks stay high before ready;
- any command is followed by NOP;
- a granted request is followed by an auto-refresh, and no run-mode refresh appears without one;
- ready never falls;
- a request never stands without pending work;
- the pending count moves by at most one and never exceeds its limit.

Only the bench scenarios can show the absolute timing: the power-up hold length, the tRP, tRC and tRSC gaps, the number of start-up refreshes, the mode word, the refresh period, and the size of the payback burst after a long starvation, all while the grant toggles at random.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PALL = 2'd1,
    OP_AREF = 2'd2,
    OP_MRS  = 2'd3
  } sdr_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_pins_t;

  localparam sdr_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_pins_t PINS_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_pins_t PINS_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdr_pins_t PINS_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdr_refi_tracker.sv
module sdr_refi_tracker #(
  parameter int REFI_CYC = 1953,
  parameter int PEND_MAX = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en,
  input  logic                             take,
  output logic [$clog2(PEND_MAX+1)-1:0]    pend,
  output logic                             pend_any
);

  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = en && (tcnt == TW'(REFI_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tcnt <= '0;
    end else if (tick) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (pend != PW'(PEND_MAX)) pend <= pend + PW'(1);
        2'b01:   pend <= pend - PW'(1);
        default: pend <= pend;
      endcase
    end
  end

  assign pend_any = (pend != '0);

  AST_PEND_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    pend <= PW'(PEND_MAX)); // R11

  AST_PEND_STEP: assert property (@(posedge clk) disable iff (rst)
    (pend != $past(pend)) |-> ((pend == $past(pend) + PW'(1)) || (pend == $past(pend) - PW'(1)))); // R11

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    take |-> pend_any); // R10

endmodule

// File: rtl/sdr_pin_driver.sv
module sdr_pin_driver
  import sdr_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int DQM_W  = 8,
  parameter int MODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  sdr_op_e           op,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              mask_release,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm
);

  localparam int AP_BIT = 10;

  sdr_pins_t         pins_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = PINS_NOP;
    addr_d = '0;
    case (op)
      OP_PALL: begin
        pins_d         = PINS_PALL;
        addr_d[AP_BIT] = 1'b1;
      end
      OP_AREF: pins_d = PINS_AREF;
      OP_MRS: begin
        pins_d = PINS_MRS;
        addr_d = ADDR_W'(mode_word);
      end
      default: pins_d = PINS_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cke   <= 1'b1;
      sd_cs_n  <= PINS_NOP.cs_n;
      sd_ras_n <= PINS_NOP.ras_n;
      sd_cas_n <= PINS_NOP.cas_n;
      sd_we_n  <= PINS_NOP.we_n;
      sd_ba    <= '0;
      sd_addr  <= '0;
      sd_dqm   <= '1;
    end else begin
      sd_cke   <= 1'b1;
      sd_cs_n  <= pins_d.cs_n;
      sd_ras_n <= pins_d.ras_n;
      sd_cas_n <= pins_d.cas_n;
      sd_we_n  <= pins_d.we_n;
      sd_ba    <= '0;
      sd_addr  <= addr_d;
      sd_dqm   <= mask_release ? '0 : '1;
    end
  end

  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
    (!sd_cs_n && !(sd_ras_n && sd_cas_n && sd_we_n))
      |=> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)); // R6

endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sdr_seq_pkg::*;
#(
  parameter int CLK_MHZ          = 125,
  parameter int POWERUP_US       = 200,
  parameter int TRP_NS           = 20,
  parameter int TRC_NS           = 70,
  parameter int TRSC_NS          = 20,
  parameter int INIT_REFS        = 8,
  parameter int REF_WINDOW_MS    = 64,
  parameter int REF_ROWS         = 4096,
  parameter int PEND_MAX         = 8,
  parameter int CAS_LAT          = 3,
  parameter int BURST_INTERLEAVE = 0,
  parameter int BURST_LEN_CODE   = 3,
  parameter int BA_W             = 2,
  parameter int ADDR_W           = 12,
  parameter int DQM_W            = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_gnt,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              ready,
  output logic              ref_req
);

  localparam int HOLD_CYC = POWERUP_US * CLK_MHZ;
  localparam int TRP_CYC  = ns_to_cyc(TRP_NS, CLK_MHZ);
  localparam int TRC_CYC  = ns_to_cyc(TRC_NS, CLK_MHZ);
  localparam int TRSC_CYC = ns_to_cyc(TRSC_NS, CLK_MHZ);
  localparam int REFI_CYC = (CLK_MHZ * REF_WINDOW_MS * 1000) / REF_ROWS;
  localparam int TMAX     = max2(max2(HOLD_CYC, TRP_CYC), max2(TRC_CYC, TRSC_CYC));
  localparam int TW       = $clog2(TMAX + 1);
  localparam int RW       = $clog2(INIT_REFS + 1);
  localparam int PW       = $clog2(PEND_MAX + 1);
  localparam int MODE_W   = 7;
  localparam logic [MODE_W-1:0] MODE_WORD =
    {3'(CAS_LAT), 1'(BURST_INTERLEAVE), 3'(BURST_LEN_CODE)};

  typedef enum logic [2:0] {
    ST_HOLD, ST_TRP, ST_ITRC, ST_TRSC, ST_RUN, ST_RTRC
  } seq_st_e;

  seq_st_e        st, st_n;
  logic [RW-1:0]  refs, refs_n;
  logic           ready_n, req_n;
  logic           t_load, t_exp;
  logic [TW-1:0]  t_val;
  logic           take;
  logic [PW-1:0]  pend;
  logic           pend_any;
  sdr_op_e        op;

  sdr_wait_timer #(.W(TW), .RST_VAL(HOLD_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  sdr_refi_tracker #(.REFI_CYC(REFI_CYC), .PEND_MAX(PEND_MAX)) u_refi (
    .clk      (clk),
    .rst      (rst),
    .en       (ready),
    .take     (take),
    .pend     (pend),
    .pend_any (pend_any)
  );

  sdr_pin_driver #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .DQM_W(DQM_W), .MODE_W(MODE_W)
  ) u_pins (
    .clk          (clk),
    .rst          (rst),
    .op           (op),
    .mode_word    (MODE_WORD),
    .mask_release (ready_n),
    .sd_cke       (sd_cke),
    .sd_cs_n      (sd_cs_n),
    .sd_ras_n     (sd_ras_n),
    .sd_cas_n     (sd_cas_n),
    .sd_we_n      (sd_we_n),
    .sd_ba        (sd_ba),
    .sd_addr      (sd_addr),
    .sd_dqm       (sd_dqm)
  );

  always_comb begin
    st_n    = st;
    refs_n  = refs;
    ready_n = ready;
    req_n   = ref_req;
    op      = OP_NOP;
    t_load  = 1'b0;
    t_val   = '0;
    take    = 1'b0;
    case (st)
      ST_HOLD: if (t_exp) begin
        op     = OP_PALL;
        t_load = 1'b1;
        t_val  = TW'(TRP_CYC - 1);
        st_n   = ST_TRP;
      end
      ST_TRP: if (t_exp) begin
        op     = OP_AREF;
        t_load = 1'b1;
        t_val  = TW'(TRC_CYC - 1);
        refs_n = RW'(1);
        st_n   = ST_ITRC;
      end
      ST_ITRC: if (t_exp) begin
        t_load = 1'b1;
        if (refs == RW'(INIT_REFS)) begin
          op    = OP_MRS;
          t_val = TW'(TRSC_CYC - 1);
          st_n  = ST_TRSC;
        end else begin
          op     = OP_AREF;
          t_val  = TW'(TRC_CYC - 1);
          refs_n = refs + RW'(1);
        end
      end
      ST_TRSC: if (t_exp) begin
        ready_n = 1'b1;
        st_n    = ST_RUN;
      end
      ST_RUN: begin
        if (ref_req && ref_gnt) begin
          op     = OP_AREF;
          take   = 1'b1;
          req_n  = 1'b0;
          t_load = 1'b1;
          t_val  = TW'(TRC_CYC - 1);
          st_n   = ST_RTRC;
        end else begin
          req_n = pend_any;
        end
      end
      ST_RTRC: begin
        req_n = 1'b0;
        if (t_exp) st_n = ST_RUN;
      end
      default: st_n = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HOLD;
      refs    <= '0;
      ready   <= 1'b0;
      ref_req <= 1'b0;
    end else begin
      st      <= st_n;
      refs    <= refs_n;
      ready   <= ready_n;
      ref_req <= req_n;
    end
  end

  AST_MASK_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (&sd_dqm)); // R2

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R8

  AST_GRANT_GIVES_AREF: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_gnt) |=> (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n)); // R10

  AST_RUN_AREF_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (ready && !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n)
      |-> $past(ref_req && ref_gnt)); // R10

  AST_REQ_HAS_PEND: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> pend_any); // R9

endmodule

// File: tb/sdram_boot_refresh_tb.sv
module sdram_boot_refresh_tb;

  localparam int HOLD = 25000;  // 200 us * 125 MHz
  localparam int TRP  = 3;      // ceil(20 ns * 125 / 1000)
  localparam int TRC  = 9;      // ceil(70 ns * 125 / 1000)
  localparam int TRSC = 3;      // ceil(20 ns * 125 / 1000)
  localparam int REFI = 1953;   // 125 * 64 * 1000 / 4096
  localparam int NREF = 8;
  localparam int PMAX = 8;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_MRS  = 4'b0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_gnt = 1'b0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [7:0]  sd_dqm;
  logic        ready, ref_req;

  int errors = 0;
  int checks = 0;
  int c = 0;
  bit prev_rg = 1'b0;
  int proto_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_boot_refresh u_dut (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .ready(ready), .ref_req(ref_req)
  );

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic logic [11:0] exp_mode_addr(int cl, int il, int bl);
    return {5'b0, 3'(cl), 1'(il), 3'(bl)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: sample after the edge, then drive the grant for the next edge.
  task automatic step(input bit g);
    @(negedge clk);
    c++;
    if (ready && ((cmd_now() == C_AREF) != prev_rg)) proto_err++;
    ref_gnt = g;
    prev_rg = ref_req && g;
  endtask

  initial begin
    int pall_c, mrs_c, rdy_c, nref, bad_init, aref_c[$];
    logic [11:0] pall_addr, mrs_addr;
    logic [1:0]  pall_ba, mrs_ba;
    logic [7:0]  dqm_at_rdy;
    bit early_req;
    int run_c[$];
    int target, burst, last_b, min_sp;

    void'($urandom(32'd20240611));
    pall_c = -1; mrs_c = -1; rdy_c = -1; bad_init = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(cmd_now() == C_NOP, "R1 cmd in reset", cmd_now(), C_NOP);
    chk(sd_cke && (&sd_dqm) && sd_addr == 0 && sd_ba == 0, "R1 cke/dqm/addr", {sd_cke, sd_dqm}, 9'h1ff);
    chk(!ready && !ref_req, "R1 ready/req", {ready, ref_req}, 0);
    rst = 1'b0;
    c = 0;

    // Start-up with random grant noise (R12 style: grant ignored, R2)
    while (!ready && c < HOLD + 600) begin
      step(1'($urandom % 2));
      if (c == 1) chk(cmd_now() == C_NOP, "R1 first cycle NOP", cmd_now(), C_NOP);
      if (!ready && (!sd_cke || !(&sd_dqm))) bad_init++;
      case (cmd_now())
        C_NOP: ;
        C_PALL: begin pall_c = c; pall_addr = sd_addr; pall_ba = sd_ba; end
        C_AREF: aref_c.push_back(c);
        C_MRS: begin mrs_c = c; mrs_addr = sd_addr; mrs_ba = sd_ba; end
        default: bad_init++;
      endcase
      if (ready) begin rdy_c = c; dqm_at_rdy = sd_dqm; end
    end
    nref = aref_c.size();
    chk(bad_init == 0, "R2 R6 cke/mask/only-legal during start-up", bad_init, 0);
    chk(pall_c == HOLD, "R3 precharge-all cycle", pall_c, HOLD);
    chk(pall_addr == 12'h400 && pall_ba == 0, "R3 precharge-all address", pall_addr, 12'h400);
    chk(nref == NREF, "R5 start-up refresh count", nref, NREF);
    if (nref > 0) chk(aref_c[0] == pall_c + TRP, "R4 first refresh after tRP", aref_c[0], pall_c + TRP);
    for (int i = 1; i < nref; i++)
      chk(aref_c[i] - aref_c[i-1] == TRC, "R5 refresh spacing tRC", aref_c[i] - aref_c[i-1], TRC);
    if (nref > 0) chk(mrs_c == aref_c[nref-1] + TRC, "R7 mode set after tRC", mrs_c, aref_c[nref-1] + TRC);
    chk(mrs_addr == exp_mode_addr(3, 0, 3) && mrs_ba == 0, "R7 mode word", mrs_addr, exp_mode_addr(3, 0, 3));
    chk(rdy_c == mrs_c + TRSC, "R8 ready after tRSC", rdy_c, mrs_c + TRSC);
    chk(dqm_at_rdy == 8'h00, "R8 masks released with ready", dqm_at_rdy, 0);
    chk(!ref_req, "R9 no request at ready", ref_req, 0);

    // Grant held high: first request only after one interval (R9, R10)
    early_req = 1'b0;
    while (run_c.size() < 3 && c < rdy_c + 4 * REFI) begin
      step(1'b1);
      if (c < rdy_c + REFI + 1 && ref_req) early_req = 1'b1;
      if (cmd_now() == C_AREF) run_c.push_back(c);
      if (!ready) bad_init++;
    end
    chk(!early_req, "R10 grant without request ignored", early_req, 0);
    chk(run_c.size() == 3, "R9 refreshes with grant held", run_c.size(), 3);
    if (run_c.size() == 3) begin
      chk(run_c[0] == rdy_c + REFI + 2, "R9 first run refresh", run_c[0], rdy_c + REFI + 2);
      chk(run_c[1] - run_c[0] == REFI, "R10 period 1", run_c[1] - run_c[0], REFI);
      chk(run_c[2] - run_c[1] == REFI, "R10 period 2", run_c[2] - run_c[1], REFI);
    end
    chk(bad_init == 0, "R8 ready stays high", bad_init, 0);

    // Random grant latency
    for (int k = 0; k < 3 * REFI; k++) step(($urandom % 4) == 0);
    chk(proto_err == 0, "R10 refresh iff granted request", proto_err, 0);

    // Starvation beyond PMAX intervals, burst starts 5 cycles after an expiry
    target = rdy_c + REFI;
    while (target < c + 10 * REFI) target += REFI;
    target += 5;
    while (c < target) step(1'b0);
    chk(ref_req, "R9 request held while starved", ref_req, 1);
    burst = 0; last_b = -1; min_sp = 1 << 30;
    for (int k = 0; k < 300; k++) begin
      step(1'b1);
      if (cmd_now() == C_AREF) begin
        if (last_b >= 0 && c - last_b < min_sp) min_sp = c - last_b;
        last_b = c;
        burst++;
      end
    end
    chk(burst == PMAX, "R11 payback burst size", burst, PMAX);
    chk(min_sp >= TRC, "R11 burst spacing", min_sp, TRC);
    chk(!ref_req, "R11 request falls after burst", ref_req, 0);
    chk(proto_err == 0, "R10 protocol over whole run", proto_err, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", c, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule